// File: doc/BRIEF.md
# Interrupt Pin Driver with Re-arm Gap

This block turns a set of event pulses into an active-low interrupt line for a host processor. Each event source has a sticky pending bit. The host acknowledges events with a write-one-to-clear strobe that carries a mask. The line is driven low while any bit is pending, unless a gap is running.

A mode input sets what happens when the host acknowledges while at least one bit stays pending. With the mode off, the line stays low without a break. With the mode on, the line is released for a fixed gap and then driven low again. This gives a host that triggers on edges a new falling edge for the work that is still outstanding.

The gap length is counted in pulses of a timebase tick. Clock cycles with no tick do not count toward the gap. Reset is synchronous.

Top module: `irq_gap_pin`

## Requirements
- R1: A pulse on bit i of `eventIn` sets pending bit i. If no gap is running, `intN` is low from the next clock edge.
- R2: A cycle with `clrStrobe` high clears the pending bits that are set in `clrMask`. If an event pulse on the same source arrives in that same cycle, the event wins and the bit stays set.
- R3: `intN` is low exactly when at least one pending bit is set and no gap is running. At all other times it is high.
- R4: The gap starts when all of these hold in one cycle: `gapModeEn` is 1, `clrStrobe` is high, `intN` is low, and at least one bit is still pending after that cycle's update. `intN` then goes high from the next edge. It stays high for exactly GAP_TICKS `tick` pulses, and goes low again at the edge of the last pulse if a bit is still pending.
- R5: If `gapModeEn` is 0 in the same situation as R4, `intN` stays low without interruption.
- R6: A clear that leaves no bit pending releases `intN` (high) with no gap. A following event drives `intN` low at the next edge.
- R7: An event that arrives during a gap sets its pending bit. It does not shorten or restart the gap.
- R8: A clear during a running gap does not start a new gap and does not extend the current one.
- R9: Only cycles with `tick` high advance the gap. In cycles with `tick` low, a running gap stays running.
- R10: While `rst` is high at a clock edge, all pending bits are cleared, any running gap is stopped, and `intN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gapModeEn | input | 1 | 1: release the line for a gap on clear with work outstanding; 0: keep the line low |
| tick | input | 1 | Timebase pulse that counts the gap |
| eventIn | input | NUM_SRC | Event pulses, one bit per source |
| clrStrobe | input | 1 | Write-one-to-clear strobe |
| clrMask | input | NUM_SRC | Bits to clear when `clrStrobe` is high |
| intN | output | 1 | Interrupt line, active low |

## Verification
Two functions can act on the same bit in one cycle: the clear path and the event path. The bench provokes this with one vector that clears source 3 while pulsing source 3. It expects the bit to survive and the gap to start, since the line was low and work is still pending.

A second collision is an acknowledge that lands inside a running gap while a new event also arrives. The bench judges this by the cycle in which `intN` falls again. That must be exactly GAP_TICKS ticks after the first acknowledge, not later.

// File: rtl/irq_gap_pkg.sv
package irq_gap_pkg;

  // Commands from control to datapath for the gap timer
  typedef struct packed {
    logic startGap;  // load the timer and mark the gap active
    logic stepGap;   // count one tick inside the gap
    logic endGap;    // last tick reached: leave the gap
  } gapCmd_t;

endpackage

// File: rtl/irq_gap_dp.sv
module irq_gap_dp
  import irq_gap_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int GAP_TICKS = 275
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] eventIn,
  input  logic               clrStrobe,
  input  logic [NUM_SRC-1:0] clrMask,
  input  gapCmd_t            cmd,
  output logic               anyPending,
  output logic               pendingAfter,
  output logic               gapActive,
  output logic               gapLast
);

  localparam int CNT_W = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(GAP_TICKS - 1);

  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] statusNext;
  logic [NUM_SRC-1:0] clrBits;
  logic [CNT_W-1:0]   gapCnt;

  // An event in the same cycle as its clear wins, because it is ORed in last
  assign clrBits      = clrStrobe ? clrMask : '0;
  assign statusNext   = (status & ~clrBits) | eventIn;
  assign anyPending   = |status;
  assign pendingAfter = |statusNext;
  assign gapLast      = (gapCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= '0;
      gapActive <= 1'b0;
      gapCnt    <= '0;
    end else begin
      status <= statusNext;
      if (cmd.startGap) begin
        gapActive <= 1'b1;
        gapCnt    <= '0;
      end else if (cmd.endGap) begin
        gapActive <= 1'b0;
      end else if (cmd.stepGap) begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  // R1
  event_sets_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (|eventIn) |=> anyPending);

  // R10
  reset_clears_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!anyPending && !gapActive));

endmodule

// File: rtl/irq_gap_ctrl.sv
module irq_gap_ctrl
  import irq_gap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clrStrobe,
  input  logic    gapModeEn,
  input  logic    tick,
  input  logic    anyPending,
  input  logic    pendingAfter,
  input  logic    gapActive,
  input  logic    gapLast,
  output gapCmd_t cmd
);

  logic pinAsserted;

  assign pinAsserted = anyPending & ~gapActive;

  always_comb begin
    cmd          = '0;
    cmd.startGap = gapModeEn & clrStrobe & pinAsserted & pendingAfter;
    cmd.stepGap  = gapActive & tick & ~gapLast;
    cmd.endGap   = gapActive & tick & gapLast;
  end

  // R4
  single_gap_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd));

endmodule

// File: rtl/irq_gap_pin.sv
module irq_gap_pin
  import irq_gap_pkg::*;
#(
  parameter int NUM_SRC   = 4,
  parameter int GAP_TICKS = 275
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gapModeEn,
  input  logic               tick,
  input  logic [NUM_SRC-1:0] eventIn,
  input  logic               clrStrobe,
  input  logic [NUM_SRC-1:0] clrMask,
  output logic               intN
);

  gapCmd_t cmd;
  logic    anyPending;
  logic    pendingAfter;
  logic    gapActive;
  logic    gapLast;

  irq_gap_dp #(.NUM_SRC(NUM_SRC), .GAP_TICKS(GAP_TICKS)) dp_i (
    .clk          (clk),
    .rst          (rst),
    .eventIn      (eventIn),
    .clrStrobe    (clrStrobe),
    .clrMask      (clrMask),
    .cmd          (cmd),
    .anyPending   (anyPending),
    .pendingAfter (pendingAfter),
    .gapActive    (gapActive),
    .gapLast      (gapLast)
  );

  irq_gap_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .clrStrobe    (clrStrobe),
    .gapModeEn    (gapModeEn),
    .tick         (tick),
    .anyPending   (anyPending),
    .pendingAfter (pendingAfter),
    .gapActive    (gapActive),
    .gapLast      (gapLast),
    .cmd          (cmd)
  );

  // Both terms come from registers, so the line has no combinational path from inputs
  assign intN = ~(anyPending & ~gapActive);

  // R4
  gap_releases_line_chk: assert property (@(posedge clk) disable iff (rst)
    (gapModeEn && clrStrobe && !intN && pendingAfter) |=> intN);

  // R5
  no_gap_mode_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!gapModeEn && clrStrobe && !intN && pendingAfter) |=> !intN);

  // R8
  gap_only_from_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gapActive) |-> $past(!intN));

  // R9
  no_tick_no_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (gapActive && !tick) |=> gapActive);

endmodule

// File: tb/irq_gap_pin_tb.sv
`timescale 1ns/1ps
module irq_gap_pin_tb_top;

  localparam int NSRC = 4;
  localparam int GAPT = 3;
  localparam int NVEC = 24;

  logic            clk = 1'b0;
  logic            rst;
  logic            gapModeEn;
  logic            tick;
  logic [NSRC-1:0] eventIn;
  logic            clrStrobe;
  logic [NSRC-1:0] clrMask;
  logic            intN;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_gap_pin #(.NUM_SRC(NSRC), .GAP_TICKS(GAPT)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .gapModeEn (gapModeEn),
    .tick      (tick),
    .eventIn   (eventIn),
    .clrStrobe (clrStrobe),
    .clrMask   (clrMask),
    .intN      (intN)
  );

  // Each row: {event[4], clr, mask[4], mode, tick, expected intN after the edge, req number}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'b0001, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 first event pulls the line low
    {4'b0010, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 second source
    {4'b0000, 1'b1, 4'b0001, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 clear with work left starts the gap
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 pending but gap running: high
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 second tick
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 third tick ends the gap
    {4'b0000, 1'b1, 4'b0010, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 last bit cleared: released, no gap
    {4'b0100, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 new event asserts at once
    {4'b1000, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'd1},  // R1
    {4'b0000, 1'b1, 4'b0100, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 mode off: line stays low
    {4'b0000, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
    {4'b1000, 1'b1, 4'b1000, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 event beats clear, gap starts
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 no tick
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 no tick
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 first counted tick
    {4'b0001, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 event inside the gap
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 gap ends on schedule
    {4'b0000, 1'b1, 4'b1111, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 clear all
    {4'b0011, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd1},  // R1
    {4'b0000, 1'b1, 4'b0001, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 gap starts
    {4'b0100, 1'b1, 4'b0010, 1'b1, 1'b1, 1'b1, 4'd8},  // R8 clear plus event inside the gap
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b1, 4'd8},  // R8
    {4'b0000, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 no extension
    {4'b0000, 1'b1, 4'b1111, 1'b0, 1'b1, 1'b1, 4'd6}   // R6
  };

  task automatic checkPin(input logic exp, input string req);
    checks++;
    if (intN !== exp) begin
      errors++;
      $display("FAIL %s intN=%0b expected=%0b", req, intN, exp);
    end
  endtask

  task automatic drive(input logic [NSRC-1:0] ev, input logic clr,
                       input logic [NSRC-1:0] msk, input logic mode, input logic tk);
    eventIn   = ev;
    clrStrobe = clr;
    clrMask   = msk;
    gapModeEn = mode;
    tick      = tk;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive('0, 1'b0, '0, 1'b0, 1'b0);
    drive('0, 1'b0, '0, 1'b0, 1'b0);
    checkPin(1'b1, "R10 reset state");
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][15:12], VEC[i][11], VEC[i][10:7], VEC[i][6], VEC[i][5]);
      checkPin(VEC[i][4], $sformatf("R%0d row %0d", VEC[i][3:0], i));
    end

    // R10: reset in the middle of a gap
    drive(4'b0011, 1'b0, '0, 1'b1, 1'b1);
    checkPin(1'b0, "R10 setup");
    drive('0, 1'b1, 4'b0001, 1'b1, 1'b1);
    checkPin(1'b1, "R10 gap running");
    rst = 1'b1;
    drive('0, 1'b0, '0, 1'b1, 1'b1);
    checkPin(1'b1, "R10 reset during gap");
    rst = 1'b0;
    drive('0, 1'b0, '0, 1'b1, 1'b1);
    checkPin(1'b1, "R10 pending cleared");
    drive(4'b0001, 1'b0, '0, 1'b1, 1'b1);
    checkPin(1'b0, "R10 gap stopped by reset");
    for (int k = 0; k < GAPT; k++) begin
      drive('0, 1'b0, '0, 1'b1, 1'b1);
      checkPin(1'b0, "R10 no leftover gap");
    end

    // R3: an empty clear mask still counts as an acknowledge
    drive('0, 1'b1, 4'b0000, 1'b1, 1'b1);
    checkPin(1'b1, "R3 empty-mask clear opens gap");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule